// File: doc/BRIEF.md
# Token-Driven Counted Loop Engine

This block computes a small counted loop as three chained hardware fragments that pass enabling tokens to each other. A caller issues a start token that carries its own identifier. The entry fragment accepts the token, produces zeroed initial values for the index and the running sum, and forwards them. The loop fragment loads them through two-way selection muxes and then iterates. In each pass it adds the index to the sum and increments the index, and it keeps iterating while the index is below the bound `LIMIT`. When the bound is reached, the sum and the caller identifier move to the return fragment.

The return fragment fires only when two things are present: the data token, and a predicate token that comes straight from the entry fragment's enabling token. When it fires, it offers the result, steered back to the caller named at start. One computation is in flight at a time. While one is in flight, start tokens are refused.

Both edges are valid/ready streams. A start transfer takes place on a rising clock edge where `start_valid` and `start_ready` are both high. A return transfer takes place on an edge where `ret_valid` and `ret_ready` are both high. While `ret_ready` is low the block holds its offer unchanged, and nothing is lost or repeated. Reset is synchronous and active high.

Top module: `loop_token_engine`

## Requirements
- R1: In the first cycle after reset is released, `ret_valid` is 0 and `start_ready` is 1.
- R2: After a start transfer, `start_ready` is 0 from the next cycle until the cycle after the matching return transfer.
- R3: The value returned is the sum of all index values 0 .. LIMIT-1. This is 45 for the default `LIMIT` of 10.
- R4: The `ret_caller` returned equals the `start_caller` sampled on the accepted start transfer.
- R5: A start request offered while a computation is in flight has no effect: it produces no return, and it changes neither the returned value nor the returned caller.
- R6: While `ret_valid` is 1 and `ret_ready` is 0, `ret_valid` stays 1 and `ret_value` and `ret_caller` stay stable in the next cycle.
- R7: In the cycle after a return transfer, `start_ready` is 1 again. A following computation with a different caller returns its own caller and the correct value.
- R8: Exactly one return is offered per accepted start. `ret_valid` is 0 in the cycle after a return transfer.
- R9: While reset is asserted, `ret_valid` is 0 in the following cycle.
- R10: Each loop pass adds the old index to the sum and raises the index by one. Loading initial values and iterating never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_valid | input | 1 | Start token offered |
| start_ready | output | 1 | Engine idle, start token can be taken |
| start_caller | input | CALLER_W | Identifier of the invoking machine |
| ret_valid | output | 1 | Return token offered |
| ret_ready | input | 1 | Caller accepts the return token |
| ret_value | output | SUM_W | Final running sum |
| ret_caller | output | CALLER_W | Identifier the return is steered to |

## Verification
The in-RTL assertions check on every cycle that:
- `start_ready` falls after an accepted start;
- the return offer holds steady under back-pressure;
- a return transfer is not followed by a second offer;
- reset suppresses the return;
- every loop pass updates the index and sum correctly, with load and step exclusive.

Only the bench scenarios can show the following end-to-end results:
- the final sum of 45;
- the caller identifier travelling through all three fragments;
- start requests refused while busy leaving no trace;
- clean back-to-back reuse with a new caller.

// File: rtl/lte_pkg.sv
package lte_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_RUN  = 2'd1,
    LS_EXIT = 2'd2
  } loop_state_e;

  function automatic int unsigned tri_sum(input int unsigned n);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < n; k++) acc += k;
    return acc;
  endfunction

endpackage

// File: rtl/lte_pair_mux.sv
module lte_pair_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         sel_a,
  input  logic [W-1:0] b,
  input  logic         sel_b,
  input  logic [W-1:0] hold,
  output logic [W-1:0] y
);
  always_comb begin
    if (sel_a)      y = a;
    else if (sel_b) y = b;
    else            y = hold;
  end
endmodule

// File: rtl/lte_entry_stage.sv
module lte_entry_stage #(
  parameter int IDX_W    = 8,
  parameter int SUM_W    = 16,
  parameter int CALLER_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [CALLER_W-1:0] start_caller,
  input  logic                ret_done,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [IDX_W-1:0]    out_idx,
  output logic [SUM_W-1:0]    out_sum,
  output logic [CALLER_W-1:0] out_caller,
  output logic                pred_fire
);
  logic                flight_q;
  logic                valid_q;
  logic [CALLER_W-1:0] caller_q;
  logic                accept;

  assign start_ready = !flight_q;
  assign accept      = start_valid && start_ready;
  assign pred_fire   = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      flight_q <= 1'b0;
      valid_q  <= 1'b0;
      caller_q <= '0;
    end else begin
      if (accept)        flight_q <= 1'b1;
      else if (ret_done) flight_q <= 1'b0;
      if (accept) begin
        valid_q  <= 1'b1;
        caller_q <= start_caller;
      end else if (out_ready) begin
        valid_q  <= 1'b0;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_idx    = '0;
  assign out_sum    = '0;
  assign out_caller = caller_q;

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !start_ready);
endmodule

// File: rtl/lte_loop_stage.sv
module lte_loop_stage
  import lte_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int SUM_W    = 16,
  parameter int CALLER_W = 4,
  parameter int LIMIT    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IDX_W-1:0]    in_idx,
  input  logic [SUM_W-1:0]    in_sum,
  input  logic [CALLER_W-1:0] in_caller,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SUM_W-1:0]    out_sum,
  output logic [CALLER_W-1:0] out_caller
);
  localparam logic [IDX_W-1:0] LAST_IDX = (LIMIT > 0) ? IDX_W'(LIMIT - 1) : '0;

  loop_state_e         state_q;
  logic [IDX_W-1:0]    idx_q, idx_nx;
  logic [SUM_W-1:0]    sum_q, sum_nx;
  logic [CALLER_W-1:0] caller_q;
  logic                load, step;

  assign in_ready = (state_q == LS_IDLE);
  assign load     = in_valid && in_ready;
  assign step     = (state_q == LS_RUN);

  lte_pair_mux #(.W(IDX_W)) u_idx_mux (
    .a(in_idx), .sel_a(load), .b(idx_q + 1'b1), .sel_b(step),
    .hold(idx_q), .y(idx_nx));

  lte_pair_mux #(.W(SUM_W)) u_sum_mux (
    .a(in_sum), .sel_a(load), .b(sum_q + SUM_W'(idx_q)), .sel_b(step),
    .hold(sum_q), .y(sum_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LS_IDLE;
      idx_q    <= '0;
      sum_q    <= '0;
      caller_q <= '0;
    end else begin
      idx_q <= idx_nx;
      sum_q <= sum_nx;
      if (load) caller_q <= in_caller;
      unique case (state_q)
        LS_IDLE: if (load) state_q <= (LIMIT == 0) ? LS_EXIT : LS_RUN;
        LS_RUN:  if (idx_q == LAST_IDX) state_q <= LS_EXIT;
        LS_EXIT: if (out_ready) state_q <= LS_IDLE;
        default: state_q <= LS_IDLE;
      endcase
    end
  end

  assign out_valid  = (state_q == LS_EXIT);
  assign out_sum    = sum_q;
  assign out_caller = caller_q;

  p_step_update_r10: assert property (@(posedge clk) disable iff (rst)
    step |=> (idx_q == $past(idx_q) + 1'b1) && (sum_q == $past(sum_q) + SUM_W'($past(idx_q))));
  p_load_step_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load, step}));
endmodule

// File: rtl/lte_return_stage.sv
module lte_return_stage #(
  parameter int SUM_W    = 16,
  parameter int CALLER_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SUM_W-1:0]    in_sum,
  input  logic [CALLER_W-1:0] in_caller,
  input  logic                pred_fire,
  output logic                ret_valid,
  input  logic                ret_ready,
  output logic [SUM_W-1:0]    ret_value,
  output logic [CALLER_W-1:0] ret_caller,
  output logic                ret_done
);
  logic                data_full_q, pred_full_q;
  logic [SUM_W-1:0]    value_q;
  logic [CALLER_W-1:0] caller_q;

  assign in_ready  = !data_full_q;
  assign ret_valid = data_full_q && pred_full_q;
  assign ret_done  = ret_valid && ret_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_full_q <= 1'b0;
      pred_full_q <= 1'b0;
      value_q     <= '0;
      caller_q    <= '0;
    end else begin
      if (in_valid && in_ready) begin
        data_full_q <= 1'b1;
        value_q     <= in_sum;
        caller_q    <= in_caller;
      end else if (ret_done) begin
        data_full_q <= 1'b0;
      end
      if (pred_fire)     pred_full_q <= 1'b1;
      else if (ret_done) pred_full_q <= 1'b0;
    end
  end

  assign ret_value  = value_q;
  assign ret_caller = caller_q;

  p_hold_offer_r6: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_value) && $stable(ret_caller)));
endmodule

// File: rtl/loop_token_engine.sv
module loop_token_engine
  import lte_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int SUM_W    = 16,
  parameter int CALLER_W = 4,
  parameter int LIMIT    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic [CALLER_W-1:0] start_caller,
  output logic                ret_valid,
  input  logic                ret_ready,
  output logic [SUM_W-1:0]    ret_value,
  output logic [CALLER_W-1:0] ret_caller
);
  localparam longint SUM_MAX = longint'(tri_sum(LIMIT));

  if (SUM_MAX >= (longint'(1) << SUM_W) || LIMIT >= (1 << IDX_W)) begin : g_width_check
    $error("loop_token_engine: SUM_W or IDX_W too narrow for LIMIT");
  end

  logic                e2l_valid, e2l_ready, pred_fire, ret_done;
  logic [IDX_W-1:0]    e2l_idx;
  logic [SUM_W-1:0]    e2l_sum, l2r_sum;
  logic [CALLER_W-1:0] e2l_caller, l2r_caller;
  logic                l2r_valid, l2r_ready;

  lte_entry_stage #(.IDX_W(IDX_W), .SUM_W(SUM_W), .CALLER_W(CALLER_W)) u_entry (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_ready(start_ready), .start_caller(start_caller),
    .ret_done(ret_done),
    .out_valid(e2l_valid), .out_ready(e2l_ready),
    .out_idx(e2l_idx), .out_sum(e2l_sum), .out_caller(e2l_caller),
    .pred_fire(pred_fire));

  lte_loop_stage #(.IDX_W(IDX_W), .SUM_W(SUM_W), .CALLER_W(CALLER_W), .LIMIT(LIMIT)) u_loop (
    .clk(clk), .rst(rst),
    .in_valid(e2l_valid), .in_ready(e2l_ready),
    .in_idx(e2l_idx), .in_sum(e2l_sum), .in_caller(e2l_caller),
    .out_valid(l2r_valid), .out_ready(l2r_ready),
    .out_sum(l2r_sum), .out_caller(l2r_caller));

  lte_return_stage #(.SUM_W(SUM_W), .CALLER_W(CALLER_W)) u_ret (
    .clk(clk), .rst(rst),
    .in_valid(l2r_valid), .in_ready(l2r_ready),
    .in_sum(l2r_sum), .in_caller(l2r_caller),
    .pred_fire(pred_fire),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_value(ret_value), .ret_caller(ret_caller),
    .ret_done(ret_done));

  p_no_ret_in_reset_r9: assert property (@(posedge clk)
    rst |=> !ret_valid);
  p_single_return_r8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_ready) |=> !ret_valid);
endmodule

// File: tb/loop_token_engine_tb.sv
module loop_token_engine_tb;
  localparam int CW = 4;
  localparam int SW = 16;
  localparam int LIM = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_valid, start_ready, ret_valid, ret_ready;
  logic [CW-1:0] start_caller, ret_caller;
  logic [SW-1:0] ret_value;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int expected_sum;

  always #2.5 clk = ~clk;

  loop_token_engine #(.CALLER_W(CW), .SUM_W(SW), .LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_ready(start_ready), .start_caller(start_caller),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_value(ret_value), .ret_caller(ret_caller));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      finish_run();
    end
  end

  task automatic do_start(input logic [CW-1:0] who);
    @(negedge clk);
    start_valid  = 1'b1;
    start_caller = who;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic wait_ret(output bit ok);
    int n = 0;
    ok = 1'b1;
    while (!ret_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!ret_valid) begin
      ok = 1'b0;
      check("R8 return offered", 0, 1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; start_valid = 1'b0; start_caller = '0; ret_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 ret_valid under reset", ret_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ret_valid after reset", ret_valid, 0);
    check("R1 start_ready after reset", start_ready, 1);
  endtask

  task automatic t_single(input logic [CW-1:0] who);
    bit ok;
    ret_ready = 1'b1;
    do_start(who);
    check("R2 start_ready low while busy", start_ready, 0);
    wait_ret(ok);
    if (ok) begin
      check("R3 returned sum", ret_value, expected_sum);
      check("R4 returned caller", ret_caller, who);
      @(negedge clk);
      check("R8 single return", ret_valid, 0);
      check("R7 start_ready after return", start_ready, 1);
    end
  endtask

  task automatic t_busy_ignore();
    bit ok;
    int extra = 0;
    ret_ready = 1'b1;
    do_start(4'd3);
    @(negedge clk);
    start_valid = 1'b1; start_caller = 4'd12;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R5 start refused while busy", start_ready, 0);
    end
    start_valid = 1'b0;
    wait_ret(ok);
    if (ok) begin
      check("R5 sum unaffected", ret_value, expected_sum);
      check("R5 caller unaffected", ret_caller, 4'd3);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (ret_valid) extra++;
      end
      check("R5 no extra return", extra, 0);
    end
  endtask

  task automatic t_backpressure();
    bit ok;
    ret_ready = 1'b0;
    do_start(4'd9);
    wait_ret(ok);
    if (ok) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check("R6 valid held", ret_valid, 1);
        check("R6 value held", ret_value, expected_sum);
        check("R6 caller held", ret_caller, 4'd9);
      end
      check("R2 still busy under back-pressure", start_ready, 0);
      ret_ready = 1'b1;
      @(negedge clk);
      check("R8 return drained", ret_valid, 0);
      check("R7 ready after drained return", start_ready, 1);
    end
  endtask

  initial begin
    expected_sum = 0;
    for (int k = 0; k < LIM; k++) expected_sum += k;
    t_reset();
    t_single(4'd5);
    t_single(4'd10);
    t_busy_ignore();
    t_backpressure();
    t_single(4'd15);
    t_single(4'd0);
    finish_run();
  end
endmodule